// File: doc/BRIEF.md
# Flash Command Sequencer with Error Status

This block is the command front end of an embedded flash controller. Bus write cycles arrive on a valid/ready write channel. The sequencer decodes the low byte of each write as a command code. Some commands take one write. Others take two, and for those the second write carries a confirm code, program data or an address. When a command is accepted, the block issues a one-cycle start pulse and an operation kind to the auto-program or auto-erase engine. It then stays busy until the engine reports completion together with a pass/fail result.

Two sticky flags, an erase-class flag and a program-class flag, form a 2-bit error code `{erase, prog}`. The codes are:

- 11: command-sequence error.
- 10: erase or blank-check error.
- 01: program or lock-bit-write error.
- 00: no error.

Block-lock protection refuses a program or erase aimed at a locked block, unless the global lock-disable input is high. While the program-class flag is set, every command that would start an engine operation is dropped. Only the clear status command removes the flags.

Back-pressure: `wr_ready` is low for the whole time an operation runs. A write is taken only on a cycle where `wr_valid` and `wr_ready` are both high. A write offered while busy is not taken and has no effect. The engine side uses plain pulses: `op_start` is high for one cycle, and `op_done` is sampled only while busy.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows: `err_code` = 00, `busy` = 0, `wr_ready` = 1, `op_start` = 0, and `rd_mode` = 0 (array read).
- R2: The first-write codes in the low byte are FFh read array, 50h clear status, 40h program, 20h block erase, 77h lock bit program, 71h read lock status and 25h blank check. FFh sets `rd_mode` = 0. 50h clears `err_code` to 00 and sets `rd_mode` = 0. Any other code sets `err_code` = 11 (`err_code` = {erase flag, program flag}) and `rd_mode` = 1 (status).
- R3: For block erase and lock bit program, a second-write low byte of D0h starts the operation. FFh drops the command with no flag change and sets `rd_mode` = 0. Any other low byte sets `err_code` = 11 and starts nothing. The upper data byte is not looked at.
- R4: A confirmed block erase on a block with `blk_locked` = 1 sets `err_code` bit 1 and starts nothing, unless `lock_disable` = 1, in which case the erase starts.
- R5: A program command whose second write targets a block with `blk_locked` = 1 sets `err_code` bit 0 and starts nothing, unless `lock_disable` = 1.
- R6: When `op_done` arrives with `op_ok` = 0, the flags are set by operation kind. A program failure sets bit 0. An erase failure and a blank check that finds the block not blank each set bit 1. A lock bit program failure sets bit 0, unless `lock_disable` = 1. A read lock status operation never sets a flag.
- R7: While `err_code` bit 0 is 1, first writes of codes 40h, 20h, 77h, 71h and 25h are taken but dropped: no start pulse and no pending state. The next write is decoded as a new first write.
- R8: `busy` rises with `op_start`, stays high until `op_done` is sampled, and falls on the cycle after. While `busy` is high, `wr_ready` = 0 and offered writes change nothing.
- R9: The flags are sticky. No event except clear status clears a set flag, and that includes read array.
- R10: `op_start` lasts one cycle. In that cycle `op_kind` identifies the operation: 1 program, 2 erase, 3 lock bit program, 4 read lock status, 5 blank check. `op_data` and `op_blk` hold the second write's data and block. `rd_mode` becomes 2 for read lock status and 1 for the other operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Bus write offered |
| wr_ready | output | 1 | Write can be taken (low while busy) |
| wr_data | input | DATA_W (16) | Write data; low byte is the command or confirm code |
| wr_blk | input | BLK_W (6) | Block addressed by the write |
| blk_locked | input | 1 | Lock bit of the addressed block |
| lock_disable | input | 1 | Global lock protection bypass |
| op_start | output | 1 | One-cycle start to the engine |
| op_kind | output | 3 | Operation kind, valid with `op_start` |
| op_data | output | DATA_W (16) | Second-write data captured at start |
| op_blk | output | BLK_W (6) | Block captured at start |
| op_done | input | 1 | Engine completion |
| op_ok | input | 1 | Completion result; 0 means failure or not blank |
| busy | output | 1 | Operation in progress |
| err_code | output | 2 | {erase flag, program flag} |
| rd_mode | output | 2 | 0 array, 1 status, 2 lock status |

## Verification
Each two-write command is driven with three second-write low bytes: D0h, FFh and an arbitrary value. These separate confirmation, cancellation and sequence error, and a nonzero upper byte shows that only the low byte is decoded.

Program and erase are run against a locked block with `lock_disable` low and then high. This separates the lock error from a normal start. Every operation kind is also completed with a failing result, which shows which flag each kind raises and that read lock status raises none.

A pending program error followed by guarded codes and then clear status shows that the guarded writes left no pending state behind. Writes offered during an operation confirm that back-pressure drops them.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_RDARR, CMD_CLRSTS, CMD_PROG, CMD_ERASE,
    CMD_LKPROG, CMD_LKRD, CMD_BLANK, CMD_BAD
  } cmd_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_PROG = 3'd1, OP_ERASE = 3'd2,
    OP_LKPROG = 3'd3, OP_LKRD = 3'd4, OP_BLANK = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0, MODE_STATUS = 2'd1, MODE_LOCK = 2'd2
  } mode_e;

  localparam logic [7:0] CODE_RDARR  = 8'hFF;
  localparam logic [7:0] CODE_CLRSTS = 8'h50;
  localparam logic [7:0] CODE_PROG   = 8'h40;
  localparam logic [7:0] CODE_ERASE  = 8'h20;
  localparam logic [7:0] CODE_LKPROG = 8'h77;
  localparam logic [7:0] CODE_LKRD   = 8'h71;
  localparam logic [7:0] CODE_BLANK  = 8'h25;
  localparam logic [7:0] CODE_CONFIRM = 8'hD0;
  localparam logic [7:0] CODE_CANCEL  = 8'hFF;

  function automatic logic needs_confirm(cmd_e c);
    return (c == CMD_ERASE) || (c == CMD_LKPROG);
  endfunction

  function automatic op_e cmd_to_op(cmd_e c);
    case (c)
      CMD_PROG:   return OP_PROG;
      CMD_ERASE:  return OP_ERASE;
      CMD_LKPROG: return OP_LKPROG;
      CMD_LKRD:   return OP_LKRD;
      CMD_BLANK:  return OP_BLANK;
      default:    return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [7:0] code,
  output cmd_e       cmd
);
  always_comb begin
    case (code)
      CODE_RDARR:  cmd = CMD_RDARR;
      CODE_CLRSTS: cmd = CMD_CLRSTS;
      CODE_PROG:   cmd = CMD_PROG;
      CODE_ERASE:  cmd = CMD_ERASE;
      CODE_LKPROG: cmd = CMD_LKPROG;
      CODE_LKRD:   cmd = CMD_LKRD;
      CODE_BLANK:  cmd = CMD_BLANK;
      default:     cmd = CMD_BAD;
    endcase
  end
endmodule

// File: rtl/flash_err_flags.sv
module flash_err_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       set_seq,
  input  logic       set_erase,
  input  logic       set_prog,
  output logic [1:0] err
);
  logic [1:0] err_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   err_q <= 2'b00;
    else if (clr) err_q <= 2'b00;
    else          err_q <= err_q | {set_seq | set_erase, set_seq | set_prog};
  end

  assign err = err_q;

  // R9: a flag that is set stays set unless clear status is seen
  assert_sticky_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R2: a sequence error gives code 11
  assert_seq_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_seq && !clr) |=> (err_q == 2'b11));

  // R2: clear status empties both flags
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_q == 2'b00));
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BLK_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BLK_W-1:0]  wr_blk,
  input  cmd_e              cmd_in,
  input  logic              blk_locked,
  input  logic              lock_disable,
  input  logic              prog_err,
  input  logic              op_done,
  input  logic              op_ok,
  output logic              op_start,
  output op_e               op_kind,
  output logic [DATA_W-1:0] op_data,
  output logic [BLK_W-1:0]  op_blk,
  output logic              busy,
  output mode_e             rd_mode,
  output logic              clr,
  output logic              set_seq,
  output logic              set_erase,
  output logic              set_prog
);
  typedef enum logic [1:0] {S_IDLE, S_CONF, S_RUN} st_e;

  st_e               st_q, st_d;
  cmd_e              pend_q, pend_d;
  op_e               kind_q, kind_d;
  mode_e             mode_q, mode_d;
  logic              start_q, start_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic              acc, lock_block;
  logic [7:0]        code2;

  assign wr_ready   = (st_q != S_RUN);
  assign acc        = wr_valid && wr_ready;
  assign code2      = wr_data[7:0];
  assign lock_block = blk_locked && !lock_disable;

  always_comb begin
    st_d = st_q; pend_d = pend_q; kind_d = kind_q; mode_d = mode_q;
    start_d = 1'b0; data_d = data_q; blk_d = blk_q;
    clr = 1'b0; set_seq = 1'b0; set_erase = 1'b0; set_prog = 1'b0;
    case (st_q)
      S_IDLE: if (acc) begin
        case (cmd_in)
          CMD_RDARR:  mode_d = MODE_ARRAY;
          CMD_CLRSTS: begin clr = 1'b1; mode_d = MODE_ARRAY; end
          CMD_BAD:    begin set_seq = 1'b1; mode_d = MODE_STATUS; end
          default: if (!prog_err) begin
            st_d   = S_CONF;
            pend_d = cmd_in;
          end
        endcase
      end
      S_CONF: if (acc) begin
        st_d = S_IDLE;
        if (needs_confirm(pend_q) && code2 == CODE_CANCEL) begin
          mode_d = MODE_ARRAY;
        end else if (needs_confirm(pend_q) && code2 != CODE_CONFIRM) begin
          set_seq = 1'b1; mode_d = MODE_STATUS;
        end else if (pend_q == CMD_ERASE && lock_block) begin
          set_erase = 1'b1; mode_d = MODE_STATUS;
        end else if (pend_q == CMD_PROG && lock_block) begin
          set_prog = 1'b1; mode_d = MODE_STATUS;
        end else begin
          st_d    = S_RUN;
          start_d = 1'b1;
          kind_d  = cmd_to_op(pend_q);
          data_d  = wr_data;
          blk_d   = wr_blk;
          mode_d  = (pend_q == CMD_LKRD) ? MODE_LOCK : MODE_STATUS;
        end
      end
      S_RUN: if (op_done) begin
        st_d = S_IDLE;
        if (!op_ok) begin
          case (kind_q)
            OP_PROG:            set_prog  = 1'b1;
            OP_LKPROG:          set_prog  = !lock_disable;
            OP_ERASE, OP_BLANK: set_erase = 1'b1;
            default: ;
          endcase
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; pend_q <= CMD_RDARR; kind_q <= OP_NONE;
      mode_q <= MODE_ARRAY; start_q <= 1'b0;
      data_q <= '0; blk_q <= '0;
    end else begin
      st_q <= st_d; pend_q <= pend_d; kind_q <= kind_d;
      mode_q <= mode_d; start_q <= start_d;
      data_q <= data_d; blk_q <= blk_d;
    end
  end

  assign op_start = start_q;
  assign op_kind  = kind_q;
  assign op_data  = data_q;
  assign op_blk   = blk_q;
  assign busy     = (st_q == S_RUN);
  assign rd_mode  = mode_q;

  // R8: an operation stays busy until the engine reports done
  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && !op_done) |=> (st_q == S_RUN));

  // R8: busy ends on the cycle after done
  assert_done_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && op_done) |=> (st_q == S_IDLE));

  // R10: start is a single-cycle pulse issued inside a running operation
  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (st_q == S_RUN));

  // R7: guarded first writes are dropped while the program flag is set
  assert_guard_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && acc && prog_err &&
     cmd_in inside {CMD_PROG, CMD_ERASE, CMD_LKPROG, CMD_LKRD, CMD_BLANK})
    |=> (!start_q && st_q == S_IDLE));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BLK_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic              blk_locked,
  input  logic              lock_disable,
  output logic              op_start,
  output logic [2:0]        op_kind,
  output logic [DATA_W-1:0] op_data,
  output logic [BLK_W-1:0]  op_blk,
  input  logic              op_done,
  input  logic              op_ok,
  output logic              busy,
  output logic [1:0]        err_code,
  output logic [1:0]        rd_mode
);
  cmd_e  cmd;
  op_e   kind;
  mode_e mode;
  logic  clr, set_seq, set_erase, set_prog;

  flash_cmd_decode u_dec (
    .code (wr_data[7:0]),
    .cmd  (cmd)
  );

  flash_seq_ctrl #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_ctrl (
    .clk, .rst_n, .wr_valid, .wr_ready, .wr_data, .wr_blk,
    .cmd_in       (cmd),
    .blk_locked, .lock_disable,
    .prog_err     (err_code[0]),
    .op_done, .op_ok, .op_start,
    .op_kind      (kind),
    .op_data, .op_blk, .busy,
    .rd_mode      (mode),
    .clr, .set_seq, .set_erase, .set_prog
  );

  flash_err_flags u_flags (
    .clk, .rst_n, .clr, .set_seq, .set_erase, .set_prog,
    .err (err_code)
  );

  assign op_kind = kind;
  assign rd_mode = mode;

  // R8: no write is taken while an operation runs
  assert_no_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_data = '0;
  logic [5:0]  wr_blk = '0;
  logic        blk_locked = 1'b0;
  logic        lock_disable = 1'b0;
  logic        op_start;
  logic [2:0]  op_kind;
  logic [15:0] op_data;
  logic [5:0]  op_blk;
  logic        op_done = 1'b0;
  logic        op_ok = 1'b1;
  logic        busy;
  logic [1:0]  err_code;
  logic [1:0]  rd_mode;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_cmd_seq dut_i (
    .clk, .rst_n, .wr_valid, .wr_ready, .wr_data, .wr_blk,
    .blk_locked, .lock_disable, .op_start, .op_kind, .op_data, .op_blk,
    .op_done, .op_ok, .busy, .err_code, .rd_mode
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one write offered for one cycle; returns at the negedge after the taking edge
  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic engine_done(input logic ok);
    @(negedge clk); op_done = 1'b1; op_ok = ok;
    @(negedge clk); op_done = 1'b0; op_ok = 1'b1;
  endtask

  task automatic clear_status();
    wr(16'h0050);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "err_code", err_code, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "wr_ready", wr_ready, 1);
    chk("R1", "op_start", op_start, 0);
    chk("R1", "rd_mode", rd_mode, 0);
  endtask

  task automatic t_single_codes();
    wr(16'h0033);
    chk("R2", "bad code err", err_code, 3);
    chk("R2", "bad code mode", rd_mode, 1);
    wr(16'h00FF);
    chk("R9", "read array keeps flags", err_code, 3);
    chk("R2", "read array mode", rd_mode, 0);
    clear_status();
    chk("R2", "clear status", err_code, 0);
  endtask

  task automatic t_erase_run();
    wr(16'h0020);
    wr_blk = 6'd3;
    wr(16'hABD0);
    chk("R3", "confirm start", op_start, 1);
    chk("R10", "kind erase", op_kind, 2);
    chk("R10", "captured blk", op_blk, 3);
    chk("R10", "status mode", rd_mode, 1);
    chk("R8", "busy at start", busy, 1);
    chk("R8", "ready low", wr_ready, 0);
    @(negedge clk);
    chk("R10", "start one cycle", op_start, 0);
    wr(16'h00FF);
    chk("R8", "write while busy ignored", rd_mode, 1);
    chk("R8", "still busy", busy, 1);
    engine_done(1'b1);
    chk("R8", "busy cleared", busy, 0);
    chk("R6", "erase pass no error", err_code, 0);
    wr_blk = 6'd0;
  endtask

  task automatic t_confirm_variants();
    wr(16'h0077); wr(16'h12FF);
    chk("R3", "cancel no start", op_start, 0);
    chk("R3", "cancel no flag", err_code, 0);
    chk("R3", "cancel array mode", rd_mode, 0);
    wr(16'h0020); wr(16'h0012);
    chk("R3", "bad confirm no start", op_start, 0);
    chk("R3", "bad confirm err", err_code, 3);
    clear_status();
    wr(16'h0077); wr(16'h00D0);
    chk("R3", "lock prog start", op_start, 1);
    chk("R10", "kind lock prog", op_kind, 3);
    engine_done(1'b1);
  endtask

  task automatic t_locks();
    blk_locked = 1'b1;
    wr(16'h0020); wr(16'h00D0);
    chk("R4", "locked erase no start", op_start, 0);
    chk("R4", "locked erase err", err_code, 2);
    clear_status();
    wr(16'h0040); wr(16'h5A5A);
    chk("R5", "locked prog no start", op_start, 0);
    chk("R5", "locked prog err", err_code, 1);
    clear_status();
    lock_disable = 1'b1;
    wr(16'h0020); wr(16'h00D0);
    chk("R4", "lock disabled erase start", op_start, 1);
    engine_done(1'b1);
    wr(16'h0040); wr(16'h5A5A);
    chk("R5", "lock disabled prog start", op_start, 1);
    chk("R10", "kind program", op_kind, 1);
    chk("R10", "captured data", op_data, 16'h5A5A);
    engine_done(1'b1);
    chk("R5", "no error", err_code, 0);
    lock_disable = 1'b0;
    blk_locked = 1'b0;
  endtask

  task automatic fail_op(input logic [15:0] c1, input logic [15:0] c2,
                         input int exp_err, input string what);
    wr(c1); wr(c2);
    chk("R6", {what, " started"}, op_start, 1);
    engine_done(1'b0);
    chk("R6", what, err_code, exp_err);
    clear_status();
  endtask

  task automatic t_failures();
    fail_op(16'h0040, 16'h1234, 1, "program fail");
    fail_op(16'h0020, 16'h00D0, 2, "erase fail");
    fail_op(16'h0025, 16'h0000, 2, "blank not blank");
    fail_op(16'h0077, 16'h00D0, 1, "lock prog fail");
    lock_disable = 1'b1;
    fail_op(16'h0077, 16'h00D0, 0, "lock prog fail exempt");
    lock_disable = 1'b0;
    wr(16'h0071); wr(16'h0000);
    chk("R10", "kind lock read", op_kind, 4);
    chk("R10", "lock mode", rd_mode, 2);
    engine_done(1'b0);
    chk("R6", "lock read no error", err_code, 0);
  endtask

  task automatic t_guard();
    blk_locked = 1'b1;
    wr(16'h0040); wr(16'h0000);
    blk_locked = 1'b0;
    chk("R7", "program flag set", err_code, 1);
    wr(16'h0020);
    chk("R7", "erase dropped", op_start, 0);
    wr(16'h0025);
    chk("R7", "blank dropped", op_start, 0);
    wr(16'h0040);
    chk("R7", "program dropped", op_start, 0);
    wr(16'h0050);
    chk("R7", "no data phase, clear taken", err_code, 0);
    chk("R7", "no start from clear", op_start, 0);
    chk("R7", "not busy", busy, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single_codes();
    t_erase_run();
    t_confirm_variants();
    t_locks();
    t_failures();
    t_guard();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule